// File: doc/BRIEF.md
# Memory Type Range Resolver

This block maps a physical address to the caching type that applies to it. The type is chosen from three sources of configuration:

- a table of type bytes that covers the lowest megabyte in three granule sizes;
- a bank of variable base/mask range registers;
- a default-type register with separate enables for the fixed table and the variable ranges.

An optional upper memory limit marks the region from 4 GiB up to that limit as write-back. Software loads every register through a single indexed write port. The block then answers one lookup per cycle, one cycle after the request.

The block resolves only the type of one start address. When two or more variable ranges cover the same address, a precedence rule merges their types into one result. If the block has never been configured, or both enables are clear, it returns a reserved code and raises an "off" flag.

Top module: `memtype_resolver`

## Requirements
- R1: After reset `res_valid` is 0. Until the default-type register has been written at least once, every lookup returns type 0xFF with `res_off` = 1.
- R2: If bits 11 and 10 of the default-type register are both 0, every lookup returns 0xFF with `res_off` = 1. Otherwise `res_off` is 0.
- R3: The fixed table has 88 bytes. It is used when bit 10 of the default register is 1 and the address is below 0x100000. The byte index is chosen by address range:
  - below 0x80000: the index is addr>>16;
  - from 0x80000 to 0xBFFFF: the index is 8+((addr-0x80000)>>14);
  - from 0xC0000 to 0xFFFFF: the index is 24+((addr-0xC0000)>>12).
- R4: If bit 10 is 0, addresses below 0x100000 are resolved like any other address.
- R5: If the fixed table does not apply and bit 11 (variable enable) is 0, the result is the default type held in bits 7:0.
- R6: A variable range takes part only when bit 11 of its mask register is 1. It matches when (addr & mask) equals (base & mask) over address bits 12 and up. Its type is bits 7:0 of its base register.
- R7: The types of matching ranges are merged in index order, using these rules:
  - if either type is uncacheable (0), the result is 0 and the merge stops;
  - write-back (6) merged with write-through (4) gives 4;
  - any other unequal pair gives 0;
  - an equal pair keeps its value.
- R8: Suppose the upper memory limit is nonzero, the address is at or above 4 GiB and below the limit, and the merge did not stop on uncacheable. Then the result is write-back (6), and it overrides any merged variable type.
- R9: When no active range matches and neither R3 nor R8 applies, the result is the default type.
- R10: Each cycle with `lk_valid` high produces exactly one cycle of `res_valid` on the next cycle. `res_valid` is never high otherwise.
- R11: A lookup issued in the same cycle as a configuration write resolves with the configuration as it was before that write.
- R12: Configuration selector codes are: 0 = fixed table byte, 1 = range base, 2 = range mask, 3 = default-type register, 4 = upper memory limit. Writes whose index is out of range for the selected target are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Target register group (R12) |
| cfg_idx | input | 7 | Entry index within the group |
| cfg_wdata | input | ADDR_W | Write data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Physical address to resolve |
| res_valid | output | 1 | Result valid, one cycle after request |
| res_type | output | 8 | Effective memory type |
| res_off | output | 1 | Resolver not configured or disabled |

## Verification
A configuration write and a lookup can fall in the same cycle. The lookup must then see the old register contents, because the write lands on the same edge that captures the result. The bench drives a write to the default type, and separately a write to a range base, together with a lookup that depends on that register. It checks that the response carries the previous type and that the next lookup carries the new one. The upper memory limit and a variable range match can also apply to the same address. The bench therefore places overlapping ranges above 4 GiB and checks when the limit overrides the merge and when it does not.

// File: rtl/memtype_pkg.sv
package memtype_pkg;
  localparam logic [7:0] MT_UC  = 8'h00;
  localparam logic [7:0] MT_WC  = 8'h01;
  localparam logic [7:0] MT_WT  = 8'h04;
  localparam logic [7:0] MT_WP  = 8'h05;
  localparam logic [7:0] MT_WB  = 8'h06;
  localparam logic [7:0] MT_OFF = 8'hFF;

  localparam int FIX_ENTRIES = 88;
  localparam int CFG_IDX_W   = 7;

  typedef enum logic [2:0] {
    SEL_FIX  = 3'd0,
    SEL_BASE = 3'd1,
    SEL_MASK = 3'd2,
    SEL_DEF  = 3'd3,
    SEL_TOP  = 3'd4
  } cfg_sel_e;

  function automatic logic [7:0] mt_merge(input logic [7:0] a, input logic [7:0] b);
    if (a == MT_UC || b == MT_UC) return MT_UC;
    if ((a == MT_WB && b == MT_WT) || (a == MT_WT && b == MT_WB)) return MT_WT;
    if (a != b) return MT_UC;
    return a;
  endfunction
endpackage

// File: rtl/mtr_fixed_table.sv
module mtr_fixed_table #(
  parameter int DEPTH = 88,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [7:0]       rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (int'(widx) < DEPTH)) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];

  // R3
  fx_index_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(ridx) < DEPTH);
endmodule

// File: rtl/mtr_ctrl.sv
module mtr_ctrl #(
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_def,
  input  logic              we_top,
  input  logic [7:0]        def_type_in,
  input  logic              fix_en_in,
  input  logic              var_en_in,
  input  logic [ADDR_W-1:0] top_in,
  output logic              loaded,
  output logic [7:0]        def_type,
  output logic              fix_en,
  output logic              var_en,
  output logic [ADDR_W-1:0] top_lim
);
  always_ff @(posedge clk) begin
    if (rst) begin
      loaded   <= 1'b0;
      def_type <= 8'h00;
      fix_en   <= 1'b0;
      var_en   <= 1'b0;
      top_lim  <= '0;
    end else begin
      if (we_def) begin
        loaded   <= 1'b1;
        def_type <= def_type_in;
        fix_en   <= fix_en_in;
        var_en   <= var_en_in;
      end
      if (we_top) top_lim <= top_in;
    end
  end
endmodule

// File: rtl/mtr_var_bank.sv
module mtr_var_bank
  import memtype_pkg::*;
#(
  parameter int ADDR_W  = 40,
  parameter int NUM_VAR = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we_base,
  input  logic               we_mask,
  input  logic [CFG_IDX_W-1:0] widx,
  input  logic [ADDR_W-13:0] base_in,
  input  logic [7:0]         type_in,
  input  logic [ADDR_W-12:0] mask_in,
  input  logic [ADDR_W-13:0] addr_pg,
  output logic               hit,
  output logic               uc_stop,
  output logic [7:0]         hit_type
);
  localparam int PG_W = ADDR_W - 12;

  logic [NUM_VAR-1:0] hitv;
  logic [7:0]         rtype [NUM_VAR];

  for (genvar g = 0; g < NUM_VAR; g++) begin : g_rng
    logic [PG_W-1:0] base_q;
    logic [PG_W-1:0] mask_q;
    logic            act_q;
    logic [7:0]      type_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q <= '0;
        mask_q <= '0;
        act_q  <= 1'b0;
        type_q <= 8'h00;
      end else if (int'(widx) == g) begin
        if (we_base) begin
          base_q <= base_in;
          type_q <= type_in;
        end
        if (we_mask) begin
          mask_q <= mask_in[PG_W:1];
          act_q  <= mask_in[0];
        end
      end
    end

    assign hitv[g]  = act_q && (((addr_pg ^ base_q) & mask_q) == '0);
    assign rtype[g] = type_q;
  end

  always_comb begin
    logic [7:0] nxt;
    hit      = 1'b0;
    uc_stop  = 1'b0;
    hit_type = MT_UC;
    nxt      = MT_UC;
    for (int i = 0; i < NUM_VAR; i++) begin
      if (hitv[i] && !uc_stop) begin
        if (!hit) begin
          hit      = 1'b1;
          hit_type = rtype[i];
        end else begin
          nxt      = mt_merge(hit_type, rtype[i]);
          hit_type = nxt;
          if (nxt == MT_UC) uc_stop = 1'b1;
        end
      end
    end
  end

  // R7
  merge_needs_pair_chk: assert property (@(posedge clk) disable iff (rst)
    uc_stop |-> ($countones(hitv) >= 2));
endmodule

// File: rtl/memtype_resolver.sv
module memtype_resolver
  import memtype_pkg::*;
#(
  parameter int  ADDR_W    = 40,
  parameter int  NUM_VAR   = 8,
  parameter bit  HAVE_FIX  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_sel,
  input  logic [CFG_IDX_W-1:0] cfg_idx,
  input  logic [ADDR_W-1:0]    cfg_wdata,
  input  logic                 lk_valid,
  input  logic [ADDR_W-1:0]    lk_addr,
  output logic                 res_valid,
  output logic [7:0]           res_type,
  output logic                 res_off
);
  localparam int PG_W = ADDR_W - 12;

  logic we_fix, we_base, we_mask, we_def, we_top;
  logic idx_var_ok;

  assign idx_var_ok = int'(cfg_idx) < NUM_VAR;
  assign we_fix  = cfg_we && (cfg_sel == SEL_FIX);
  assign we_base = cfg_we && (cfg_sel == SEL_BASE) && idx_var_ok;
  assign we_mask = cfg_we && (cfg_sel == SEL_MASK) && idx_var_ok;
  assign we_def  = cfg_we && (cfg_sel == SEL_DEF);
  assign we_top  = cfg_we && (cfg_sel == SEL_TOP);

  logic              loaded, fix_en, var_en;
  logic [7:0]        def_type;
  logic [ADDR_W-1:0] top_lim;

  mtr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .we_def(we_def), .we_top(we_top),
    .def_type_in(cfg_wdata[7:0]),
    .fix_en_in(cfg_wdata[10]), .var_en_in(cfg_wdata[11]),
    .top_in(cfg_wdata),
    .loaded(loaded), .def_type(def_type),
    .fix_en(fix_en), .var_en(var_en), .top_lim(top_lim)
  );

  logic       low_meg;
  logic [7:0] fx_rdata;
  logic       fx_use;

  assign low_meg = (lk_addr[ADDR_W-1:20] == '0);

  if (HAVE_FIX) begin : g_fix
    logic [CFG_IDX_W-1:0] fx_idx;

    always_comb begin
      if (!lk_addr[19])      fx_idx = {4'd0, lk_addr[18:16]};
      else if (!lk_addr[18]) fx_idx = 7'd8  + {3'd0, lk_addr[17:14]};
      else                   fx_idx = 7'd24 + {1'b0, lk_addr[17:12]};
    end

    mtr_fixed_table #(.DEPTH(FIX_ENTRIES), .IDX_W(CFG_IDX_W)) u_fix (
      .clk(clk), .rst(rst),
      .we(we_fix), .widx(cfg_idx), .wdata(cfg_wdata[7:0]),
      .ridx(fx_idx), .rdata(fx_rdata)
    );
    assign fx_use = fix_en && low_meg;
  end else begin : g_nofix
    assign fx_rdata = MT_UC;
    assign fx_use   = 1'b0;
  end

  logic       v_hit, v_stop;
  logic [7:0] v_type;

  mtr_var_bank #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR)) u_var (
    .clk(clk), .rst(rst),
    .we_base(we_base), .we_mask(we_mask), .widx(cfg_idx),
    .base_in(cfg_wdata[ADDR_W-1:12]), .type_in(cfg_wdata[7:0]),
    .mask_in(cfg_wdata[ADDR_W-1:11]),
    .addr_pg(lk_addr[ADDR_W-1:12]),
    .hit(v_hit), .uc_stop(v_stop), .hit_type(v_type)
  );

  logic top_hit;
  assign top_hit = (top_lim != '0) && (lk_addr[ADDR_W-1:32] != '0) && (lk_addr < top_lim);

  logic [7:0] nx_type;
  logic       nx_off;

  always_comb begin
    nx_off  = 1'b0;
    nx_type = def_type;
    if (!loaded || (!fix_en && !var_en)) begin
      nx_off  = 1'b1;
      nx_type = MT_OFF;
    end else if (fx_use) begin
      nx_type = fx_rdata;
    end else if (!var_en) begin
      nx_type = def_type;
    end else if (v_stop) begin
      nx_type = MT_UC;
    end else if (top_hit) begin
      nx_type = MT_WB;
    end else if (v_hit) begin
      nx_type = v_type;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_type  <= MT_OFF;
      res_off   <= 1'b1;
    end else begin
      res_valid <= lk_valid;
      if (lk_valid) begin
        res_type <= nx_type;
        res_off  <= nx_off;
      end
    end
  end

  // R10
  res_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);

  // R10
  no_stray_res_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !res_valid);

  // R1
  unloaded_off_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !loaded) |=> (res_off && res_type == MT_OFF));

  // R2
  off_code_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_off) |-> (res_type == MT_OFF));
endmodule

// File: tb/memtype_resolver_tb.sv
`timescale 1ns/1ps
module memtype_resolver_tb;
  localparam int AW = 40;
  localparam int NV = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [6:0]    cfg_idx = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          lk_valid = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic          res_valid;
  logic [7:0]    res_type;
  logic          res_off;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  memtype_resolver #(.ADDR_W(AW), .NUM_VAR(NV), .HAVE_FIX(1'b1)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .res_valid(res_valid), .res_type(res_type), .res_off(res_off)
  );

  // shadow configuration for the reference model
  logic [7:0]    sh_fix [88];
  logic [AW-1:0] sh_base [NV];
  logic [AW-1:0] sh_mask [NV];
  logic [AW-1:0] sh_def;
  logic [AW-1:0] sh_top;
  bit            sh_loaded;

  function automatic logic [7:0] merge_ref(logic [7:0] a, logic [7:0] b);
    if (a == 8'h00 || b == 8'h00) return 8'h00;
    if (a == 8'h06 && b == 8'h04) return 8'h04;
    if (a == 8'h04 && b == 8'h06) return 8'h04;
    if (a != b) return 8'h00;
    return a;
  endfunction

  function automatic logic [7:0] ref_type(logic [AW-1:0] a);
    logic [7:0] acc;
    bit any, stopped;
    logic [AW-1:0] m;
    acc = 8'h00; any = 0; stopped = 0;
    if (!sh_loaded || sh_def[11:10] == 2'b00) return 8'hFF;
    if (sh_def[10] && a < 40'h100000) begin
      if (a < 40'h80000) return sh_fix[a >> 16];
      if (a < 40'hC0000) return sh_fix[8 + ((a - 40'h80000) >> 14)];
      return sh_fix[24 + ((a - 40'hC0000) >> 12)];
    end
    if (!sh_def[11]) return sh_def[7:0];
    for (int i = 0; i < NV; i++) begin
      m = sh_mask[i] & ~40'hFFF;
      if (!stopped && sh_mask[i][11] && ((a & m) == (sh_base[i] & m))) begin
        if (!any) begin acc = sh_base[i][7:0]; any = 1; end
        else begin
          acc = merge_ref(acc, sh_base[i][7:0]);
          if (acc == 8'h00) stopped = 1;
        end
      end
    end
    if (stopped) return 8'h00;
    if (sh_top != 0 && a >= 40'h1_0000_0000 && a < sh_top) return 8'h06;
    if (any) return acc;
    return sh_def[7:0];
  endfunction

  task automatic fail_msg(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_fail++;
    $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
  endtask

  task automatic cfg(logic [2:0] sel, int idx, logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = 7'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      3'd0: if (idx < 88) sh_fix[idx] = d[7:0];
      3'd1: if (idx < NV) sh_base[idx] = d;
      3'd2: if (idx < NV) sh_mask[idx] = d;
      3'd3: begin sh_def = d; sh_loaded = 1; end
      3'd4: sh_top = d;
      default: ;
    endcase
  endtask

  task automatic look(string req, logic [AW-1:0] a, logic [7:0] exp);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    n_chk++;
    if (!res_valid) fail_msg(req, "res_valid", 64'(res_valid), 64'd1);
    else if (res_type !== exp) fail_msg(req, "type", 64'(res_type), 64'(exp));
    else if (res_off !== (exp == 8'hFF)) fail_msg(req, "off", 64'(res_off), 64'(exp == 8'hFF));
    @(negedge clk);
    n_chk++;
    if (res_valid) fail_msg("R10", "res_valid idle", 64'(res_valid), 64'd0);
  endtask

  task automatic look_ref(string req, logic [AW-1:0] a);
    look(req, a, ref_type(a));
  endtask

  function automatic logic [AW-1:0] mk_mask(logic [AW-1:0] size);
    return (~(size - 1)) | 40'h800;
  endfunction

  task automatic t_reset;
    n_chk++;
    if (res_valid !== 1'b0) fail_msg("R1", "reset res_valid", 64'(res_valid), 64'd0);
    look("R1", 40'h1234000, 8'hFF);
    look("R1", 40'h0, 8'hFF);
  endtask

  task automatic t_global_off;
    for (int i = 0; i < 88; i++) cfg(3'd0, i, 40'((i * 5 + 1) & 8'h7F));
    cfg(3'd3, 0, 40'h006);
    look("R2", 40'h5000, 8'hFF);
    look("R2", 40'h2_0000_0000, 8'hFF);
  endtask

  task automatic t_fixed;
    cfg(3'd3, 0, 40'h400 | 40'h05);
    look("R3", 40'h00000, sh_fix[0]);
    look("R3", 40'h0FFFF, sh_fix[0]);
    look("R3", 40'h10000, sh_fix[1]);
    look("R3", 40'h7FFFF, sh_fix[7]);
    look("R3", 40'h80000, sh_fix[8]);
    look("R3", 40'h83FFF, sh_fix[8]);
    look("R3", 40'h84000, sh_fix[9]);
    look("R3", 40'hBFFFF, sh_fix[23]);
    look("R3", 40'hC0000, sh_fix[24]);
    look("R3", 40'hC0FFF, sh_fix[24]);
    look("R3", 40'hC1000, sh_fix[25]);
    look("R3", 40'hFFFFF, sh_fix[87]);
    look("R5", 40'h100000, 8'h05);
    cfg(3'd0, 90, 40'h33);
    look("R12", 40'hFFFFF, sh_fix[87]);
  endtask

  task automatic t_var_basic;
    cfg(3'd3, 0, 40'h800 | 40'h00);
    cfg(3'd1, 0, 40'h0 | 40'h06);
    cfg(3'd2, 0, mk_mask(40'h8000_0000));
    look("R4", 40'h50000, 8'h06);
    look("R6", 40'h7FFF_FFFF, 8'h06);
    look("R9", 40'h8000_0000, 8'h00);
    cfg(3'd1, 1, 40'h1000_0000 | 40'h01);
    cfg(3'd2, 1, mk_mask(40'h10_0000) & ~40'h800);
    look("R6", 40'h1000_0000, 8'h06);
    cfg(3'd2, 1, mk_mask(40'h10_0000) | 40'h7FF);
    look("R7", 40'h1000_0ABC, 8'h00);
    cfg(3'd1, 5, 40'h0);
    cfg(3'd2, 5, 40'h0);
    cfg(3'd1, 9, 40'h0 | 40'h00);
    cfg(3'd2, 9, mk_mask(40'h1000));
    look("R12", 40'h2000_0000, 8'h06);
    cfg(3'd3, 0, 40'h400 | 40'h01);
    look("R5", 40'h2000_0000, 8'h01);
  endtask

  task automatic t_overlap;
    cfg(3'd3, 0, 40'h800 | 40'h05);
    cfg(3'd1, 1, 40'h4000_0000 | 40'h04);
    cfg(3'd2, 1, mk_mask(40'h100_0000));
    look("R7", 40'h4000_1000, 8'h04);
    cfg(3'd1, 1, 40'h4000_0000 | 40'h01);
    look("R7", 40'h4000_1000, 8'h00);
    cfg(3'd1, 1, 40'h4000_0000 | 40'h06);
    look("R7", 40'h4000_1000, 8'h06);
    cfg(3'd1, 0, 40'h0 | 40'h00);
    look("R7", 40'h4000_1000, 8'h00);
    cfg(3'd1, 0, 40'h0 | 40'h04);
    cfg(3'd1, 2, 40'h4000_0000 | 40'h04);
    cfg(3'd2, 2, mk_mask(40'h1000));
    look("R7", 40'h4000_0000, 8'h04);
    look_ref("R9", 40'h9000_0000);
  endtask

  task automatic t_top;
    for (int i = 0; i < NV; i++) begin cfg(3'd1, i, 40'h0); cfg(3'd2, i, 40'h0); end
    cfg(3'd3, 0, 40'h800 | 40'h00);
    cfg(3'd4, 0, 40'h8_0000_0000);
    look("R8", 40'h1_0000_0000, 8'h06);
    look("R8", 40'h7_FFFF_F000, 8'h06);
    look("R8", 40'h8_0000_0000, 8'h00);
    look("R8", 40'h0FFF_F000, 8'h00);
    cfg(3'd1, 3, 40'h2_0000_0000 | 40'h04);
    cfg(3'd2, 3, mk_mask(40'h1000_0000));
    look("R8", 40'h2_0000_0000, 8'h06);
    cfg(3'd1, 4, 40'h2_0000_0000 | 40'h01);
    cfg(3'd2, 4, mk_mask(40'h1000_0000));
    look("R8", 40'h2_0000_0000, 8'h00);
    cfg(3'd4, 0, 40'h0);
    cfg(3'd2, 4, 40'h0);
    look("R8", 40'h2_0000_0000, 8'h04);
    look_ref("R9", 40'h3_0000_0000);
  endtask

  task automatic t_same_cycle;
    logic [7:0] old_exp;
    old_exp = ref_type(40'h3_0000_0000);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd3; cfg_idx = 0; cfg_wdata = 40'h800 | 40'h05;
    lk_valid = 1'b1; lk_addr = 40'h3_0000_0000;
    @(negedge clk);
    cfg_we = 1'b0; lk_valid = 1'b0;
    sh_def = 40'h805;
    n_chk++;
    if (res_type !== old_exp) fail_msg("R11", "same-cycle default", 64'(res_type), 64'(old_exp));
    look("R11", 40'h3_0000_0000, 8'h05);
    old_exp = ref_type(40'h2_0000_0000);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd1; cfg_idx = 3; cfg_wdata = 40'h2_0000_0000 | 40'h06;
    lk_valid = 1'b1; lk_addr = 40'h2_0000_0000;
    @(negedge clk);
    cfg_we = 1'b0; lk_valid = 1'b0;
    sh_base[3] = 40'h2_0000_0006;
    n_chk++;
    if (res_type !== old_exp) fail_msg("R11", "same-cycle base", 64'(res_type), 64'(old_exp));
    look("R11", 40'h2_0000_0000, 8'h06);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = 40'hC1000;
    @(negedge clk);
    lk_addr = 40'h2_0000_0000;
    n_chk++;
    if (!res_valid) fail_msg("R10", "b2b first", 64'(res_valid), 64'd1);
    @(negedge clk);
    lk_valid = 1'b0;
    n_chk++;
    if (!res_valid || res_type !== ref_type(40'h2_0000_0000))
      fail_msg("R10", "b2b second", 64'(res_type), 64'(ref_type(40'h2_0000_0000)));
    @(negedge clk);
    n_chk++;
    if (res_valid) fail_msg("R10", "b2b idle", 64'(res_valid), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 88; i++) sh_fix[i] = 8'h00;
    for (int i = 0; i < NV; i++) begin sh_base[i] = '0; sh_mask[i] = '0; end
    sh_def = '0; sh_top = '0; sh_loaded = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_global_off();
    t_fixed();
    t_var_basic();
    t_overlap();
    t_top();
    t_same_cycle();
    t_back_to_back();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule